// File: doc/BRIEF.md
# Run-Time Windowed Majority Debouncer

This block cleans up a bank of slow mechanical inputs such as switches or buttons. Each raw pin first crosses into the clock domain through a two-flop synchronizer. While filtering is switched on, a free-running prescaler produces a slow sample tick, nominally every 10 ms. On each tick, every line pushes its synchronized level into its own 16-entry history. The filtered output of a line is the majority of the newest N entries of that line's history.

The window length N is a register value that software can change at any time. The history depth never changes. The vote masks off the taps older than N, counts the ones that remain, and compares the count against half the window.

An even N is balanced with one constant-0 tap and one constant-1 tap, so the vote never ties. While filtering is switched off, the history freezes and the output follows the synchronized pins. Two control words are written through a single-cycle write strobe.

Top module: `gdeb_majority_debouncer`

## Requirements
- R1: Each of the LINES (default 8) outputs is decided only by its own pin's history; lines never combine.
- R2: With filtering off, `deb_out` equals `pin_in` as it was three rising edges earlier (two synchronizer flops plus the output flop).
- R3: A write with `wr_addr`=0 loads the filter-enable bit from `wr_data[0]`. Writes take effect at the edge that samples `wr_en`, and the output reflects the new setting one edge later. While filtering is off, the history does not capture.
- R4: The history holds 16 samples, with the newest at tap 0. It shifts only on an edge where the sample tick is high and filtering is on.
- R5: A write with `wr_addr`=1 loads the window N from `wr_data[4:0]`. For odd N from 1 to 15, the output one edge after a history shift is 1 exactly when more than N/2 of the newest N samples are 1.
- R6: For even N from 2 to 16, a forced-0 tap and a forced-1 tap are added, so the result equals the majority of the newest N-1 samples.
- R7: N=0 acts as N=1, so the output is the newest sample. N from 17 to 31 acts as N=15.
- R8: The sample tick occurs every DIV clock cycles. The first tick is on the DIV-th rising edge after reset release.
- R9: Reset clears every history and the output to 0, sets filtering off, and sets N to 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | LINES | Raw asynchronous input pins |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_addr | input | 1 | 0: enable word, 1: window word |
| wr_data | input | DATA_W | Write data |
| deb_out | output | LINES | Filtered (or passed-through) levels |

## Verification
With filtering off, a pin change is due at `deb_out` on the third rising edge. With filtering on, a vote result is due one edge after the tick edge that shifts the history. A register write changes the output from the second edge after the strobe. The bench keeps a cycle-stepped reference that advances on the same edges from the requirements, drives inputs on falling edges, and compares `deb_out` on every falling edge. Each comparison therefore lands midway between the edge that produces a result and the next one.

// File: rtl/gdeb_pkg.sv
package gdeb_pkg;

   typedef enum logic {
      GDEB_REG_ENABLE = 1'b0,
      GDEB_REG_WINDOW = 1'b1
   } gdeb_reg_e;

   // Number of real taps that take part in the vote for a requested window.
   function automatic int unsigned gdeb_taps(input int unsigned req,
                                             input int unsigned depth);
      int unsigned kmax;
      kmax = (depth % 2 == 1) ? depth : depth - 1;
      if (req == 0)            return 1;
      else if (req > depth)    return kmax;
      else if (req % 2 == 0)   return req - 1;   // balanced pair cancels
      else                     return req;
   endfunction

endpackage

// File: rtl/gdeb_sync.sv
module gdeb_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gdeb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gdeb_tick.sv
module gdeb_tick #(
   parameter int DIV = 2_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad
         $error("gdeb_tick: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/gdeb_line.sv
module gdeb_line #(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic             sample,
   input  logic [CNT_W-1:0] taps,
   output logic [DEPTH-1:0] hist,
   output logic             vote
);
   logic [DEPTH-1:0] hist_q;
   logic [CNT_W-1:0] ones;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hist_q <= '0;
      else if (shift) hist_q <= {hist_q[DEPTH-2:0], sample};
   end

   always_comb begin
      ones = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (CNT_W'(i) < taps) ones = ones + CNT_W'(hist_q[i]);
      end
   end

   assign vote = ({ones, 1'b0} > {1'b0, taps});
   assign hist = hist_q;
endmodule

// File: rtl/gdeb_majority_debouncer.sv
module gdeb_majority_debouncer #(
   parameter int LINES   = 8,
   parameter int DEPTH   = 16,
   parameter int DIV     = 2_000_000,
   parameter int DATA_W  = 8,
   parameter int DEF_WIN = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  pin_in,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [LINES-1:0]  deb_out
);
   import gdeb_pkg::*;

   localparam int WIN_W = $clog2(DEPTH + 1);
   localparam int CNT_W = $clog2(DEPTH + 1);

   generate
      if (LINES < 1)       begin : g_bad_lines $error("LINES must be positive"); end
      if (DEPTH < 3)       begin : g_bad_depth $error("DEPTH must be at least 3"); end
      if (DATA_W < WIN_W)  begin : g_bad_data  $error("DATA_W too narrow for window"); end
   endgenerate

   logic [LINES-1:0]       sync_lvl;
   logic                   tick;
   logic                   en_q;
   logic [WIN_W-1:0]       win_q;
   logic [CNT_W-1:0]       taps;
   logic [LINES-1:0]       vote_vec;
   logic [LINES*DEPTH-1:0] hist_flat;
   logic                   shift;

   gdeb_sync #(.W(LINES), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl));

   gdeb_tick #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         win_q <= WIN_W'(DEF_WIN);
      end else if (wr_en) begin
         case (gdeb_reg_e'(wr_addr))
            GDEB_REG_ENABLE: en_q  <= wr_data[0];
            GDEB_REG_WINDOW: win_q <= wr_data[WIN_W-1:0];
            default: ;
         endcase
      end
   end

   assign taps  = CNT_W'(gdeb_taps(int'(win_q), DEPTH));
   assign shift = tick & en_q;

   for (genvar l = 0; l < LINES; l++) begin : g_line
      gdeb_line #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_line (
         .clk    (clk),
         .rst_n  (rst_n),
         .shift  (shift),
         .sample (sync_lvl[l]),
         .taps   (taps),
         .hist   (hist_flat[l*DEPTH +: DEPTH]),
         .vote   (vote_vec[l]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    deb_out <= '0;
      else if (en_q) deb_out <= vote_vec;
      else           deb_out <= sync_lvl;
   end
endmodule

// File: rtl/gdeb_checker.sv
module gdeb_checker #(
   parameter int LINES = 8,
   parameter int DEPTH = 16,
   parameter int DIV   = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [LINES-1:0]       pin_in,
   input logic [LINES-1:0]       deb_out,
   input logic                   en_q,
   input logic                   tick,
   input logic [LINES*DEPTH-1:0] hist
);
   logic [1:0]  age;
   logic [31:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age <= '0;
         gap <= '0;
      end else begin
         if (age != 2'd3) age <= age + 1'b1;
         gap <= tick ? 32'd0 : gap + 1;
      end
   end

   // R2: pass-through latency of three edges
   p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && $past(!en_q)) |-> deb_out == $past(pin_in, 3));

   // R4: history frozen unless ticking while enabled
   p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && en_q) |=> $stable(hist));

   // R5: unanimous history gives unanimous vote
   p_all_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && (&hist)) |=> deb_out == '1);

   p_all_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && hist == '0) |=> deb_out == '0);

   // R8: tick spacing
   p_tick_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> gap == 32'(DIV - 1));
endmodule

bind gdeb_majority_debouncer gdeb_checker #(
   .LINES(LINES), .DEPTH(DEPTH), .DIV(DIV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .deb_out(deb_out),
   .en_q(en_q), .tick(tick), .hist(hist_flat));

// File: tb/gdeb_majority_debouncer_tb.sv
module gdeb_majority_debouncer_tb;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin_in = '0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] deb_out;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   gdeb_majority_debouncer #(.DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .deb_out(deb_out));

   // Reference built from the requirements
   logic [7:0]       m_s1, m_s2, m_out;
   logic [7:0][15:0] m_hist;
   logic             m_en;
   logic [4:0]       m_win;
   int               m_cnt;
   logic [7:0]       m_vote;

   function automatic logic ref_vote(input logic [15:0] h, input logic [4:0] n);
      int k, c;
      if (n == 0)        k = 1;        // R7
      else if (n > 16)   k = 15;       // R7
      else if (n[0] == 0) k = n - 1;   // R6
      else               k = n;        // R5
      c = 0;
      for (int i = 0; i < k; i++) c += h[i];
      return (2 * c > k);
   endfunction

   always_comb begin
      for (int l = 0; l < 8; l++) m_vote[l] = ref_vote(m_hist[l], m_win);
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_out <= '0; m_hist <= '0;
         m_en <= 1'b0; m_win <= 5'd5; m_cnt <= 0;
      end else begin
         m_s1  <= pin_in;
         m_s2  <= m_s1;
         m_out <= m_en ? m_vote : m_s2;
         if (m_en && m_cnt == DIV - 1)
            for (int l = 0; l < 8; l++) m_hist[l] <= {m_hist[l][14:0], m_s2[l]};
         m_cnt <= (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
         if (wr_en) begin
            if (wr_addr == 1'b0) m_en  <= wr_data[0];
            else                 m_win <= wr_data[4:0];
         end
      end
   end

   task automatic check(input string tag);
      n_checks++;
      if (deb_out !== m_out) begin
         n_errors++;
         $display("FAIL %s: deb_out=%h expected=%h at %0t", tag, deb_out, m_out, $time);
      end
   endtask

   // mode 0: hold, 1: slow random flips, 2: fully random
   task automatic run(input int cycles, input int mode, input string tag);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         check(tag);
         if (mode == 1) begin
            for (int b = 0; b < 8; b++)
               if ($urandom % 8 == 0) pin_in[b] = ~pin_in[b];
         end else if (mode == 2) begin
            pin_in = 8'($urandom);
         end
      end
   endtask

   task automatic write(input logic a, input logic [7:0] d, input string tag);
      @(negedge clk);
      check(tag);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      check(tag);
      wr_en = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240917));
      repeat (4) @(negedge clk);
      check("R9");                       // output held at 0 in reset
      rst_n = 1'b1;
      run(3, 0, "R9");

      run(40, 2, "R2");                  // filter off: pass-through
      write(1'b0, 8'h01, "R3");          // enable
      run(200, 1, "R5");                 // default window 5
      write(1'b1, 8'd7, "R5");
      run(200, 1, "R5");
      write(1'b1, 8'd4, "R6");
      run(200, 1, "R6");
      write(1'b1, 8'd16, "R6");
      run(200, 1, "R6");
      write(1'b1, 8'd0, "R7");
      run(150, 1, "R7");
      write(1'b1, 8'd25, "R7");
      run(200, 1, "R7");

      write(1'b1, 8'd1, "R8");           // newest-sample window shows tick timing
      pin_in = 8'h00; run(20, 0, "R8");
      pin_in = 8'hFF; run(12, 0, "R8");

      write(1'b1, 8'd3, "R1");           // distinct per-line patterns
      pin_in = 8'h5A; run(60, 0, "R1");
      pin_in = 8'hA5; run(60, 0, "R1");
      run(100, 1, "R1");

      write(1'b0, 8'h00, "R3");          // off: pass-through, history frozen
      run(40, 2, "R3");
      pin_in = 8'h0F; run(6, 0, "R3");
      write(1'b0, 8'h01, "R4");          // re-enable: vote on frozen history
      run(3, 0, "R4");
      run(100, 1, "R4");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule